// File: doc/BRIEF.md
# Compare-Match Timer Channel with Event Flags and Waveform Output

This block is one 8-bit timer channel. An up-counter advances on an enable tick. Each counter value reached on a tick is compared with two programmable compare values, A and B. A match on either value, or a wrap of the counter past its top value, raises a sticky event flag. Each flag is also presented as a level interrupt request. A match can also change a waveform output pin. The change is chosen by a 2-bit action field per compare: hold, force low, force high or invert. When enabled, a match on compare A also issues a one-cycle converter start request.

Software reaches the channel through a small register bus. The bus has four addresses: the counter (read only), compare A, compare B, and a combined status/control byte. A flag can be cleared by software only after it has been seen as set. Software first reads the status byte while the flag is 1, then writes 0 to that bit. A transfer engine can also clear a compare flag with an acknowledge pulse, unless an external keep input holds the flag. One build option removes the converter trigger. In that build, control bit 4 is fixed.

Top module: `cmt_channel`

## Requirements
- R1: After reset the counter is 0. It increases by one on every clock edge where `tick` is 1, wraps from 0xFF to 0x00, and reads back at bus address 0.
- R2: The compare-A flag (status bit 6) sets on the tick edge where the counter takes a value equal to compare A (address 1). The compare-B flag (status bit 7) does the same with compare B (address 2).
- R3: The overflow flag (status bit 5) sets on the tick edge where the counter goes from 0xFF to 0x00.
- R4: Software clears a flag by reading status (address 3) while the flag is 1 and then writing 0 to its bit. A write of 0 without that read leaves the flag set. A write of 1 never changes a flag. The read-arm stays in place until the flag clears.
- R5: The read-arm is kept per flag, so a zero-write clears only the armed flags. A flag that is set again in the same cycle as its clear stays set and loses its arm.
- R6: A pulse on `xfer_ack_a` or `xfer_ack_b` clears the compare-A or compare-B flag when `xfer_keep` is 0. It has no effect when `xfer_keep` is 1.
- R7: Status bits 4:0 read back as written: bit 4 is the converter trigger enable, bits 3:2 the B action and bits 1:0 the A action. All status bits reset to 0. The compare registers read back as written.
- R8: The action encoding is 00 hold, 01 drive 0, 10 drive 1, 11 invert. The waveform output resets to 0 and changes only on the edge of a match.
- R9: When A and B match on the same edge, the B action field alone decides the waveform output.
- R10: `adc_start` is a one-cycle pulse on the compare-A match edge when bit 4 is 1. There is no pulse when bit 4 is 0.
- R11: With `HAS_ADC` = 0, status bit 4 reads 1, ignores writes, and `adc_start` stays 0.
- R12: `irq_cmp_b`, `irq_cmp_a` and `irq_ovf` equal status bits 7, 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 counter, 1 compare A, 2 compare B, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| xfer_ack_a | input | 1 | Transfer acknowledge for compare-A request |
| xfer_ack_b | input | 1 | Transfer acknowledge for compare-B request |
| xfer_keep | input | 1 | 1 = acknowledges do not clear flags |
| wave_out | output | 1 | Waveform output |
| adc_start | output | 1 | Converter start pulse |
| irq_cmp_a | output | 1 | Compare-A flag level |
| irq_cmp_b | output | 1 | Compare-B flag level |
| irq_ovf | output | 1 | Overflow flag level |

## Verification
Two pairs of functions can land on the same edge. The first pair is a flag being set by a match and the same flag being cleared by an armed zero-write. The bench provokes this by driving a status write together with the tick that hits compare A. It expects the flag to survive, and a second zero-write without a fresh read to leave it set. The second pair is the A and B waveform actions. The bench sets both compare values to the next count for all sixteen action pairs and checks the output against a model in which only the B action applies.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    localparam int unsigned DW = 8;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } wave_act_e;

    // bit layout matches status[4:0]
    typedef struct packed {
        logic      adc_en;
        wave_act_e act_b;
        wave_act_e act_a;
    } cmt_ctrl_t;

    // bit layout matches status[7:5]
    typedef struct packed {
        logic hit_b;
        logic hit_a;
        logic wrap;
    } cmt_evt_t;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_CMPA = 2'd1;
    localparam logic [1:0] ADDR_CMPB = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    function automatic logic wave_apply(wave_act_e act, logic cur);
        case (act)
            ACT_HOLD: return cur;
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return ~cur;
        endcase
    endfunction

endpackage

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    output logic [W-1:0] cnt,
    output cmt_evt_t     evt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_nxt;
    assign cnt_nxt = cnt + 1'b1;

    // events are reported on the edge that loads the new count
    always_comb begin
        evt.hit_a = tick && (cnt_nxt == cmp_a);
        evt.hit_b = tick && (cnt_nxt == cmp_b);
        evt.wrap  = tick && (cnt == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt_nxt;
    end

    a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt));
    a_r3_wrap_lands_on_zero: assert property (@(posedge clk) disable iff (rst)
        evt.wrap |=> (cnt == '0));
endmodule

// File: rtl/cmt_flags.sv
module cmt_flags #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         rd_stb,
    input  logic         wr_stb,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] hw_clr,
    output logic [N-1:0] flag
);
    logic [N-1:0] arm;

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic clr;
        assign clr = hw_clr[i] || (wr_stb && !wdata[i] && arm[i]);

        always_ff @(posedge clk) begin
            if (rst) begin
                flag[i] <= 1'b0;
                arm[i]  <= 1'b0;
            end else begin
                if (set[i])   flag[i] <= 1'b1;
                else if (clr) flag[i] <= 1'b0;

                if (set[i] || clr)          arm[i] <= 1'b0;
                else if (rd_stb && flag[i]) arm[i] <= 1'b1;
            end
        end

        a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> flag[i]);
        a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
            (!flag[i] && !set[i]) |=> !flag[i]);
        a_r5_unarmed_survives: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && !arm[i] && !hw_clr[i]) |=> flag[i]);
    end
endmodule

// File: rtl/cmt_wave.sv
module cmt_wave
    import cmt_pkg::*;
#(
    parameter bit HAS_ADC = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  cmt_evt_t  evt,
    input  cmt_ctrl_t ctrl,
    output logic      wave,
    output logic      adc_start
);
    wave_act_e act;

    // B outranks A on a shared edge
    always_comb begin
        act = ACT_HOLD;
        if (evt.hit_b)      act = ctrl.act_b;
        else if (evt.hit_a) act = ctrl.act_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave      <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            wave      <= wave_apply(act, wave);
            adc_start <= HAS_ADC && evt.hit_a && ctrl.adc_en;
        end
    end

    a_r8_wave_still: assert property (@(posedge clk) disable iff (rst)
        !(evt.hit_a || evt.hit_b) |=> $stable(wave));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

    if (!HAS_ADC) begin : g_noadc
        a_r11_no_request: assert property (@(posedge clk) disable iff (rst)
            !adc_start);
    end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
    import cmt_pkg::*;
#(
    parameter bit HAS_ADC = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          xfer_ack_a,
    input  logic          xfer_ack_b,
    input  logic          xfer_keep,
    output logic          wave_out,
    output logic          adc_start,
    output logic          irq_cmp_a,
    output logic          irq_cmp_b,
    output logic          irq_ovf
);
    localparam int unsigned NFLAG = $bits(cmt_evt_t);

    logic [DW-1:0] cmp_a, cmp_b, cnt;
    cmt_ctrl_t     ctrl;
    cmt_evt_t      evt, flags, hw_clr;
    logic          wr_stat, rd_stat;

    assign wr_stat = bus_sel && bus_we  && (bus_addr == ADDR_STAT);
    assign rd_stat = bus_sel && !bus_we && (bus_addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_a <= '0;
            cmp_b <= '0;
            ctrl  <= '0;
        end else if (bus_sel && bus_we) begin
            case (bus_addr)
                ADDR_CMPA: cmp_a <= bus_wdata;
                ADDR_CMPB: cmp_b <= bus_wdata;
                ADDR_STAT: begin
                    ctrl.act_a  <= wave_act_e'(bus_wdata[1:0]);
                    ctrl.act_b  <= wave_act_e'(bus_wdata[3:2]);
                    ctrl.adc_en <= HAS_ADC && bus_wdata[4];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        hw_clr.hit_a = xfer_ack_a && !xfer_keep;
        hw_clr.hit_b = xfer_ack_b && !xfer_keep;
        hw_clr.wrap  = 1'b0;
    end

    cmt_counter #(.W(DW)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt(cnt), .evt(evt)
    );

    cmt_flags #(.N(NFLAG)) u_flags (
        .clk(clk), .rst(rst), .set(evt), .rd_stb(rd_stat), .wr_stb(wr_stat),
        .wdata(bus_wdata[DW-1 -: NFLAG]), .hw_clr(hw_clr), .flag(flags)
    );

    cmt_wave #(.HAS_ADC(HAS_ADC)) u_wave (
        .clk(clk), .rst(rst), .evt(evt), .ctrl(ctrl),
        .wave(wave_out), .adc_start(adc_start)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CNT:  bus_rdata = cnt;
            ADDR_CMPA: bus_rdata = cmp_a;
            ADDR_CMPB: bus_rdata = cmp_b;
            default:   bus_rdata = {flags, (HAS_ADC ? ctrl.adc_en : 1'b1),
                                    ctrl.act_b, ctrl.act_a};
        endcase
    end

    assign irq_cmp_a = flags.hit_a;
    assign irq_cmp_b = flags.hit_b;
    assign irq_ovf   = flags.wrap;

    a_r6_keep_blocks_ack: assert property (@(posedge clk) disable iff (rst)
        (xfer_keep && irq_cmp_a && !(wr_stat && !bus_wdata[6])) |=> irq_cmp_a);
    a_r7_ctrl_follows_write: assert property (@(posedge clk) disable iff (rst)
        wr_stat |=> (ctrl.act_a == $past(bus_wdata[1:0])));
endmodule

// File: tb/sim_cmt_channel.sv
`timescale 1ns/1ps
module sim_cmt_channel;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       ack_a = 1'b0, ack_b = 1'b0, keep = 1'b0;
    logic [7:0] rdata0, rdata1;
    logic       wave0, wave1, adc0, adc1, ia0, ib0, io0, ia1, ib1, io1;

    int checks = 0;
    int errors = 0;
    logic [7:0] cnt = 8'd0;

    always #2.5 clk = ~clk;

    cmt_channel #(.HAS_ADC(1'b1)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata0),
        .xfer_ack_a(ack_a), .xfer_ack_b(ack_b), .xfer_keep(keep),
        .wave_out(wave0), .adc_start(adc0),
        .irq_cmp_a(ia0), .irq_cmp_b(ib0), .irq_ovf(io0));

    cmt_channel #(.HAS_ADC(1'b0)) u1 (
        .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata1),
        .xfer_ack_a(ack_a), .xfer_ack_b(ack_b), .xfer_keep(keep),
        .wave_out(wave1), .adc_start(adc1),
        .irq_cmp_a(ia1), .irq_cmp_b(ib1), .irq_ovf(io1));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d0, output logic [7:0] d1);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d0 = rdata0; d1 = rdata1;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic step(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
        cnt = cnt + 8'(n);
    endtask

    function automatic logic model(input logic [1:0] act, input logic cur);
        case (act)
            2'b00: return cur;
            2'b01: return 1'b0;
            2'b10: return 1'b1;
            default: return ~cur;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s0, s1;
        logic       w;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R7 R1 R8 R11 reset state
        rd(2'd3, s0, s1);
        chk("R7 reset status", s0, 8'h00);
        chk("R11 reset status bit4", s1, 8'h10);
        rd(2'd0, s0, s1);
        chk("R1 reset count", s0, 0);
        chk("R8 reset wave", wave0, 0);

        // R7 readback
        wr(2'd1, 8'h40);
        wr(2'd2, 8'h80);
        rd(2'd1, s0, s1); chk("R7 cmpA readback", s0, 8'h40);
        rd(2'd2, s0, s1); chk("R7 cmpB readback", s0, 8'h80);
        wr(2'd3, 8'h1F);
        rd(2'd3, s0, s1);
        chk("R7 ctrl readback", s0, 8'h1F);
        chk("R11 ctrl readback", s1, 8'h1F);
        wr(2'd3, 8'h00);
        rd(2'd3, s0, s1);
        chk("R11 bit4 fixed", s1, 8'h10);

        // R1 R2 R3 R12 full counter sweep
        for (int i = 1; i <= 256; i++) begin
            step(1);
            rd(2'd0, s0, s1);
            chk("R1 count", s0, i % 256);
            rd(2'd3, s0, s1);
            chk("R2 R3 flags", s0, {(i >= 8'h80) ? 1'b1 : 1'b0,
                                    (i >= 8'h40) ? 1'b1 : 1'b0,
                                    (i == 256) ? 1'b1 : 1'b0, 5'b0});
            chk("R12 irq", {ib0, ia0, io0}, s0[7:5]);
        end
        wr(2'd3, 8'h00);
        chk("R4 armed clear all", {ib0, ia0, io0}, 0);

        // R4 unarmed write and write of one
        wr(2'd1, cnt + 8'd1);
        wr(2'd2, cnt + 8'd2);
        step(2);
        wr(2'd3, 8'h00);
        chk("R4 zero without read", {ib0, ia0}, 2'b11);
        wr(2'd3, 8'hC0);
        chk("R4 write one", {ib0, ia0}, 2'b11);
        rd(2'd3, s0, s1);
        // R5 per-bit clear
        wr(2'd3, 8'h80);
        chk("R5 selective clear", {ib0, ia0}, 2'b10);
        wr(2'd3, 8'h00);
        chk("R4 arm persists", ib0, 0);

        // R5 set and clear on the same edge
        wr(2'd1, cnt + 8'd1);
        step(1);
        rd(2'd3, s0, s1);
        wr(2'd1, cnt + 8'd1);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h00; tick = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0; cnt = cnt + 8'd1;
        chk("R5 set wins", ia0, 1);
        wr(2'd3, 8'h00);
        chk("R5 arm dropped by set", ia0, 1);
        rd(2'd3, s0, s1);
        wr(2'd3, 8'h00);
        chk("R5 rearmed clear", ia0, 0);

        // R6 acknowledge clears
        wr(2'd1, cnt + 8'd1);
        step(1);
        keep = 1'b1; ack_a = 1'b1; @(negedge clk); ack_a = 1'b0;
        chk("R6 keep blocks A", ia0, 1);
        keep = 1'b0; ack_a = 1'b1; @(negedge clk); ack_a = 1'b0;
        chk("R6 ack clears A", ia0, 0);
        wr(2'd2, cnt + 8'd1);
        step(1);
        keep = 1'b1; ack_b = 1'b1; @(negedge clk); ack_b = 1'b0;
        chk("R6 keep blocks B", ib0, 1);
        keep = 1'b0; ack_b = 1'b1; @(negedge clk); ack_b = 1'b0;
        chk("R6 ack clears B", ib0, 0);

        // R8 R9 R10 R11 all action pairs
        w = 1'b0;
        for (int sa = 0; sa < 4; sa++) begin
            for (int sb = 0; sb < 4; sb++) begin
                logic en;
                en = sb[0];
                wr(2'd3, {3'b0, en, 2'(sb), 2'(sa)});
                wr(2'd1, cnt + 8'd1);
                wr(2'd2, cnt + 8'd2);
                step(1);
                w = model(2'(sa), w);
                chk("R8 A action", wave0, w);
                chk("R10 pulse on A", adc0, en);
                chk("R11 no request", adc1, 0);
                step(1);
                w = model(2'(sb), w);
                chk("R8 B action", wave0, w);
                chk("R10 no pulse on B", adc0, 0);
                wr(2'd1, cnt + 8'd1);
                wr(2'd2, cnt + 8'd1);
                step(1);
                w = model(2'(sb), w);
                chk("R9 B priority", wave0, w);
                chk("R10 pulse on shared", adc0, en);
                @(negedge clk);
                chk("R10 one cycle", adc0, 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule